// File: doc/BRIEF.md
# Delayed-Transaction Discard Timer Unit

A bridge that accepts a delayed transaction holds it until the initiator that issued it comes back with the same request. This unit watches how long each held request waits. It has one timer for the upstream (primary) side and one for the downstream (secondary) side. A timer starts when its side reports that a request has been held. It stops when the side reports that the request was retried. If the initiator does not return in time, the timer frees the held entry with a one-cycle discard pulse.

Each side has its own select bit that picks a long timeout or a short timeout. Both lengths are powers of two. Any expiry, from either side, sets one shared sticky status bit. Software clears that bit by writing a one to it. An enable bit decides whether an expiry also pulls the active-low system-error output low for one clock.

The bus protocol, the request matching logic and the data buffers sit outside this unit. They reach it only through the held and retried strobes.

Top module: `disc_timer_unit`

## Requirements
- R1: After reset, `reg_rdata` reads 0, both discard outputs are 0 and `serr_n` is 1. The register layout is: bit 0 selects the primary timeout, bit 1 selects the secondary timeout, bit 2 enables error reporting and bit 3 is the status bit. A write stores bits 2:0 of `reg_wdata` exactly as given.
- R2: With its select bit at 0, a timer that sees its held strobe at clock edge E0 raises its discard output for the single cycle that follows edge E(2^LONG_EXP), provided no retry arrives first.
- R3: With its select bit at 1, the same timing applies with 2^SHORT_EXP in place of 2^LONG_EXP.
- R4: A retried strobe sampled at any edge up to and including the expiry edge stops the timer. No discard is then produced.
- R5: A discard pulse lasts one cycle, and the timer is idle afterwards. A timer that has not seen a held strobe never produces a discard.
- R6: The status bit (bit 3) reads 1 from the edge that follows any discard pulse, on either side.
- R7: Writing a 1 to bit 3 clears the status bit. Writing a 0 to bit 3 leaves the status bit unchanged.
- R8: If a clearing write and a discard pulse meet at the same edge, the status bit ends up at 1.
- R9: With bit 2 at 1, `serr_n` is 0 for exactly the one cycle that follows the status-setting edge. With bit 2 at 0, an expiry never drives `serr_n` low.
- R10: When both timers expire in the same cycle, `serr_n` is low for a single cycle only.
- R11: Changing a select bit while a timer is running does not change the timeout of the request that timer is already holding.
- R12: The two timers run independently. Strobes on one side never cause a discard on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: bits 2:0 are control bits, bit 3 clears the status bit when 1 |
| reg_rdata | output | 4 | Read data: {status, error enable, secondary select, primary select} |
| pri_held | input | 1 | Primary side: a delayed request is now held |
| pri_retried | input | 1 | Primary side: the initiator has repeated the held request |
| sec_held | input | 1 | Secondary side: a delayed request is now held |
| sec_retried | input | 1 | Secondary side: the initiator has repeated the held request |
| pri_discard | output | 1 | One-cycle pulse that frees the expired primary entry |
| sec_discard | output | 1 | One-cycle pulse that frees the expired secondary entry |
| serr_n | output | 1 | Active-low system-error output |

## Verification
The bench builds the unit with LONG_EXP=6 and SHORT_EXP=3, so the two timeouts are 64 and 8 cycles. At these lengths every expiry, including retries that land exactly on the expiry edge or one cycle before or after it, can be checked cycle by cycle within a short run. The shifts and widths still scale with the parameters, so the default build with 2^15 and 2^10 uses the same logic.

// File: rtl/disc_timer_pkg.sv
// Package: types shared by the discard timer unit.
// Assumes: the control fields sit in register bits 2:0, and the status bit sits in bit 3.
package disc_timer_pkg;

    // Number of bridge sides that have a timer.
    localparam int NUM_SIDES = 2;

    // Control register fields. The first field listed is the most significant bit.
    typedef struct packed {
        logic err_en;     // bit 2: report expiry on serr_n
        logic sec_short;  // bit 1: secondary side uses the short timeout
        logic pri_short;  // bit 0: primary side uses the short timeout
    } ctrl_t;

endpackage

// File: rtl/disc_timer_core.sv
// Module: one discard timer.
// It starts on a held strobe and stops on a retried strobe. If it runs for the
// selected number of cycles, it emits a one-cycle discard pulse and goes idle.
// Assumes: LONG_EXP >= SHORT_EXP >= 1. The timeout is chosen when the count starts.
// Priority at an edge: held, then retried, then expiry.
module disc_timer_core #(
    parameter int LONG_EXP  = 15,
    parameter int SHORT_EXP = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic short_sel,
    input  logic held,
    input  logic retried,
    output logic discard
);
    localparam int CW = LONG_EXP;
    localparam logic [CW-1:0] LONG_LAST  = {CW{1'b1}};
    localparam logic [CW-1:0] SHORT_LAST = LONG_LAST >> (LONG_EXP - SHORT_EXP);

    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Purpose: load, advance, stop or expire the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            last    <= '0;
            discard <= 1'b0;
        end else begin
            discard <= 1'b0;
            if (held) begin
                active <= 1'b1;
                cnt    <= '0;
                last   <= short_sel ? SHORT_LAST : LONG_LAST;
            end else if (retried) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (active) begin
                if (cnt == last) begin
                    discard <= 1'b1;
                    active  <= 1'b0;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/disc_timer_regs.sv
// Module: control bits, the sticky status bit and the system-error pulse.
// Assumes: expire_any is a one-cycle pulse. A set of the status bit wins over a
// clear at the same edge. serr_n follows the edge that sets the status bit.
module disc_timer_regs
    import disc_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [3:0] reg_wdata,
    input  logic       expire_any,
    output ctrl_t      ctrl,
    output logic       status,
    output logic       serr_n
);
    // Purpose: store the control bits that a register write supplies.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (reg_wr) ctrl <= ctrl_t'(reg_wdata[2:0]);
    end

    // Purpose: sticky status bit, cleared by writing a one; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                       status <= 1'b0;
        else if (expire_any)              status <= 1'b1;
        else if (reg_wr && reg_wdata[3])  status <= 1'b0;
    end

    // Purpose: one-clock low pulse per expiry cycle when reporting is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_n <= 1'b1;
        else        serr_n <= !(expire_any && ctrl.err_en);
    end
endmodule

// File: rtl/disc_timer_unit.sv
// Module: top of the discard timer unit. It holds one timer per bridge side
// and the shared register and error logic.
// Assumes: the held and retried strobes are one cycle wide and synchronous to clk.
module disc_timer_unit
    import disc_timer_pkg::*;
#(
    parameter int LONG_EXP  = 15,
    parameter int SHORT_EXP = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [3:0] reg_wdata,
    output logic [3:0] reg_rdata,
    input  logic       pri_held,
    input  logic       pri_retried,
    input  logic       sec_held,
    input  logic       sec_retried,
    output logic       pri_discard,
    output logic       sec_discard,
    output logic       serr_n
);
    ctrl_t                ctrl;
    logic                 status;
    logic [NUM_SIDES-1:0] held_v, retried_v, sel_v, discard_v;

    assign held_v    = {sec_held, pri_held};
    assign retried_v = {sec_retried, pri_retried};
    assign sel_v     = {ctrl.sec_short, ctrl.pri_short};

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        disc_timer_core #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .short_sel(sel_v[g]),
            .held     (held_v[g]),
            .retried  (retried_v[g]),
            .discard  (discard_v[g])
        );
    end

    disc_timer_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .expire_any(|discard_v),
        .ctrl      (ctrl),
        .status    (status),
        .serr_n    (serr_n)
    );

    assign pri_discard = discard_v[0];
    assign sec_discard = discard_v[1];
    assign reg_rdata   = {status, ctrl};
endmodule

// File: rtl/disc_timer_unit_chk.sv
// Module: assertion checker for disc_timer_unit. It observes ports only and is
// attached to the top module by the bind statement at the end of this file.
module disc_timer_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [3:0] reg_wdata,
    input logic [3:0] reg_rdata,
    input logic       pri_discard,
    input logic       sec_discard,
    input logic       serr_n
);
    AST_PRI_DISCARD_SHORT: assert property (@(posedge clk) disable iff (!rst_n) pri_discard |=> !pri_discard); // R5
    AST_SEC_DISCARD_SHORT: assert property (@(posedge clk) disable iff (!rst_n) sec_discard |=> !sec_discard); // R5
    AST_STATUS_ON_EXPIRY:  assert property (@(posedge clk) disable iff (!rst_n) (pri_discard || sec_discard) |=> reg_rdata[3]); // R6
    AST_W0_KEEPS_STATUS:   assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && !reg_wdata[3] && reg_rdata[3]) |=> reg_rdata[3]); // R7
    AST_W1_CLEARS_STATUS:  assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_wdata[3] && !pri_discard && !sec_discard) |=> !reg_rdata[3]); // R7
    AST_SET_BEATS_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n) (reg_wr && reg_wdata[3] && (pri_discard || sec_discard)) |=> reg_rdata[3]); // R8
    AST_SERR_ON_EXPIRY:    assert property (@(posedge clk) disable iff (!rst_n) ((pri_discard || sec_discard) && reg_rdata[2]) |=> !serr_n); // R9
    AST_SERR_HAS_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) !serr_n |-> ($past(reg_rdata[2]) && $past(pri_discard || sec_discard))); // R9
endmodule

bind disc_timer_unit disc_timer_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pri_discard(pri_discard),
    .sec_discard(sec_discard),
    .serr_n     (serr_n)
);

// File: tb/disc_timer_unit_test.sv
// Bench: directed corner cases plus a seeded random loop. Expected values come
// from the requirements (timeout length, priority and pulse timing).
module disc_timer_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LG = 6;
    localparam int SH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       pri_held = 1'b0, pri_retried = 1'b0, sec_held = 1'b0, sec_retried = 1'b0;
    logic       pri_discard, sec_discard, serr_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    disc_timer_unit #(.LONG_EXP(LG), .SHORT_EXP(SH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pri_held(pri_held), .pri_retried(pri_retried),
        .sec_held(sec_held), .sec_retried(sec_retried),
        .pri_discard(pri_discard), .sec_discard(sec_discard), .serr_n(serr_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lim(input bit sel);
        return sel ? (1 << SH) : (1 << LG);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // mask: bit 0 = primary, bit 1 = secondary. d: edge at which the retry is seen (0 = no retry).
    // clr_at_set: issue a clearing write at the status-setting edge. chg: flip the select bits at edge 2.
    task automatic run(input bit [1:0] mask, input bit sel, input bit en, input int d,
                       input bit clr_at_set, input bit chg, input string req);
        int  L;
        bit  expd;
        logic [3:0] cfg;
        L    = lim(sel);
        expd = (d == 0) || (d > L);
        cfg  = {1'b0, en, sel, sel};
        wr(cfg);
        pri_held = mask[0]; sec_held = mask[1];
        tick();
        pri_held = 1'b0; sec_held = 1'b0;
        for (int k = 1; k <= L + 3; k++) begin
            if (k == d) begin pri_retried = mask[0]; sec_retried = mask[1]; end
            if (chg && k == 2) begin reg_wr = 1'b1; reg_wdata = {1'b0, en, ~sel, ~sel}; end
            if (clr_at_set && k == L + 1) begin reg_wr = 1'b1; reg_wdata = {1'b1, cfg[2:0]}; end
            tick();
            pri_retried = 1'b0; sec_retried = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
            chk(pri_discard == (mask[0] && expd && k == L), {req, " pri_discard"}, pri_discard, mask[0] && expd && k == L);
            chk(sec_discard == (mask[1] && expd && k == L), {req, " sec_discard"}, sec_discard, mask[1] && expd && k == L);
            if (k == L + 1) begin
                chk(reg_rdata[3] == expd, {req, " R6 status"}, reg_rdata[3], expd);
                chk(serr_n == !(expd && en), {req, " R9 serr_n low"}, serr_n, !(expd && en));
            end
            if (k == L + 2)
                chk(serr_n == 1'b1, {req, " R9 R10 serr_n single pulse"}, serr_n, 1);
        end
        if (chg) wr(cfg);
        wr({1'b1, cfg[2:0]});
        chk(reg_rdata == {1'b0, cfg[2:0]}, {req, " R7 clear by one"}, reg_rdata, {1'b0, cfg[2:0]});
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 4'h0, "R1 reset rdata", reg_rdata, 0);
        chk(!pri_discard && !sec_discard, "R1 reset discards", {pri_discard, sec_discard}, 0);
        chk(serr_n == 1'b1, "R1 reset serr_n", serr_n, 1);

        wr(4'b0101);
        chk(reg_rdata == 4'b0101, "R1 layout 101", reg_rdata, 5);
        wr(4'b0010);
        chk(reg_rdata == 4'b0010, "R1 layout 010", reg_rdata, 2);
        wr(4'b0000);

        // R5: idle timers produce nothing
        for (int i = 0; i < 20; i++) begin
            tick();
            chk(!pri_discard && !sec_discard, "R5 idle no discard", {pri_discard, sec_discard}, 0);
        end

        run(2'b01, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 pri long");
        run(2'b10, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R2 R12 sec long");
        run(2'b01, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R3 pri short");
        run(2'b10, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R3 R9 sec short no enable");
        run(2'b01, 1'b1, 1'b1, lim(1), 1'b0, 1'b0, "R4 retry at expiry edge");
        run(2'b10, 1'b1, 1'b1, lim(1) - 1, 1'b0, 1'b0, "R4 retry before expiry");
        run(2'b01, 1'b1, 1'b1, lim(1) + 1, 1'b0, 1'b0, "R4 retry after expiry");
        run(2'b11, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R10 both expire");
        run(2'b01, 1'b1, 1'b1, 0, 1'b1, 1'b0, "R8 set beats clear");
        run(2'b01, 1'b0, 1'b1, 0, 1'b0, 1'b1, "R11 select change long");
        run(2'b10, 1'b1, 1'b1, 0, 1'b0, 1'b1, "R11 select change short");

        // R7: writing 0 to bit 3 keeps status
        run(2'b01, 1'b1, 1'b0, 0, 1'b1, 1'b0, "R7 setup");
        chk(reg_rdata[3] == 1'b0, "R7 cleared before", reg_rdata[3], 0);
        pri_held = 1'b1; tick(); pri_held = 1'b0;
        for (int k = 1; k <= lim(1) + 1; k++) tick();
        wr(4'b0010);
        chk(reg_rdata[3] == 1'b1, "R7 write zero keeps status", reg_rdata[3], 1);
        wr(4'b1010);
        chk(reg_rdata[3] == 1'b0, "R7 write one clears", reg_rdata[3], 0);

        for (int it = 0; it < 30; it++) begin
            bit [1:0] m;
            bit s, e;
            int d;
            m = 2'($urandom_range(3, 1));
            s = 1'($urandom_range(1, 0));
            e = 1'($urandom_range(1, 0));
            d = $urandom_range(lim(s) + 3, 0);
            run(m, s, e, d, 1'b0, 1'b0, "R2 R3 R4 R12 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule